// File: doc/BRIEF.md
# Two-Wire Bus Slave Front End with Busy-Gated Acknowledge

This block is the byte-level slave side of a two-wire serial bus, running on a fast system clock that oversamples the bus clock and data lines. It finds START and STOP conditions and shifts bytes in, most significant bit first, on rising bus-clock edges. It drives acknowledge bits and read data on the open-drain data line by asserting a pull-down request. It compares each address byte with a fixed four-bit device type code and three strap pins. After a write address, the first received byte (the register address) and the data bytes that follow are handed to a register bank as one-cycle pulses. After a read address, bytes are fetched from the bank and shifted out until the master withholds its acknowledge.

A nonvolatile-busy input from the register bank gates the acknowledge to the block's own address. A master can therefore poll for the end of a nonvolatile write by sending the address byte with either value of the read/write bit. A low level on the chip select of the companion up/down interface makes the block ignore the bus entirely.

The state machine has eight states. IDLE waits for START. ADDR shifts in the address byte. ADDR_ACK holds the acknowledge low. WR_BYTE and WR_ACK receive a byte and then acknowledge it. RD_BYTE and RD_ACK send a byte and then sample the master's acknowledge. HOLD keeps the line released until the next START or STOP. The transitions are:
- START in any state goes to ADDR.
- STOP in any state goes to IDLE.
- In ADDR, a matching address with busy low goes to ADDR_ACK; otherwise the block goes to HOLD.
- ADDR_ACK goes to RD_BYTE or WR_BYTE, according to the read/write bit.
- WR_BYTE goes to WR_ACK, and WR_ACK goes back to WR_BYTE.
- RD_BYTE goes to RD_ACK. RD_ACK goes back to RD_BYTE on a master acknowledge and to HOLD on a no-acknowledge.
- A low chip select forces IDLE.

Top module: `tw_slave_fe`

## Requirements
- R1: An address byte is accepted when bits 7..4 equal 4'b0101, bits 3..1 equal strap_i[2:0] (bit 3 = strap_i[2]), and nv_busy_i is low. Bit 0 selects the direction: 1 = read, 0 = write. The slave pulls the data line low during the ninth clock of an accepted address.
- R2: A mismatched address is not acknowledged. The data line stays released, and no byte is presented and no acknowledge is given until the next START.
- R3: If nv_busy_i is high at the end of the address byte, the address is not acknowledged, whatever the read/write bit.
- R4: In a write transfer, every received byte is acknowledged in its ninth clock and presented as a one-cycle rx_valid_o pulse carrying rx_byte_o. rx_first_o is 1 only for the first byte after the address.
- R5: In a read transfer, the slave takes rd_byte_i on the falling clock that ends the address acknowledge or a master acknowledge. It pulses rd_take_o in that cycle and drives the byte MSB first, each bit changing after a falling clock edge.
- R6: The slave keeps sending bytes while the master acknowledges. After a no-acknowledge it releases the line and sends nothing until START or STOP.
- R7: A repeated START during a transfer restarts address reception, and the next write byte is again flagged as first.
- R8: STOP returns the block to IDLE. bus_stop_o pulses for one cycle only if the block acknowledged its address since the last START.
- R9: While updn_cs_n_i is low, the bus is ignored and the data line is released.
- R10: After reset, the data line is released and no output pulse is active.
- R11: The pull-down request changes only while the synchronized bus clock is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_pull_o | output | 1 | 1 = pull the data line low |
| strap_i | input | 3 | Device address strap pins |
| updn_cs_n_i | input | 1 | Up/down interface chip select; low makes the bus ignored |
| nv_busy_i | input | 1 | Nonvolatile write cycle in progress |
| rx_valid_o | output | 1 | One-cycle pulse: received byte valid |
| rx_first_o | output | 1 | Byte is the first after the address |
| rx_byte_o | output | 8 | Received byte |
| rd_byte_i | input | 8 | Byte offered by the register bank for reading |
| rd_take_o | output | 1 | One-cycle pulse: rd_byte_i taken; the bank advances |
| bus_stop_o | output | 1 | One-cycle pulse: STOP ends an acknowledged transfer |

## Verification
A wrong state in this block shows up on the data line within one bus bit. It appears as a missing or extra acknowledge in the ninth clock, as read data shifted by one position, or as the line held low when the master expects it released. A bad byte counter or first flag shows up at the bank side at the next byte boundary, as a wrong rx_byte_o value, a wrong rx_first_o value, or a missing or extra rd_take_o pulse. A wrong selected flag shows up only at the following STOP, as a missing or spurious bus_stop_o pulse.

// File: rtl/tw_slave_pkg.sv
package tw_slave_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR_BYTE,
        ST_WR_ACK,
        ST_RD_BYTE,
        ST_RD_ACK,
        ST_HOLD
    } tw_state_t;

endpackage

// File: rtl/tw_line_cond.sv
module tw_line_cond #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic scl_prev, sda_prev;

    generate
        if (SYNC_STAGES <= 1) begin : g_one
            logic scl_r, sda_r;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_r <= 1'b1;
                    sda_r <= 1'b1;
                end else begin
                    scl_r <= scl_i;
                    sda_r <= sda_i;
                end
            end
            assign scl_s = scl_r;
            assign sda_s = sda_r;
        end else begin : g_chain
            logic [SYNC_STAGES-1:0] scl_c, sda_c;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_c <= '1;
                    sda_c <= '1;
                end else begin
                    scl_c <= {scl_c[SYNC_STAGES-2:0], scl_i};
                    sda_c <= {sda_c[SYNC_STAGES-2:0], sda_i};
                end
            end
            assign scl_s = scl_c[SYNC_STAGES-1];
            assign sda_s = sda_c[SYNC_STAGES-1];
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_prev <= scl_s;
            sda_prev <= sda_s;
        end
    end

    assign scl_rise  = scl_s & ~scl_prev;
    assign scl_fall  = ~scl_s & scl_prev;
    assign start_det = scl_s & scl_prev & sda_prev & ~sda_s;
    assign stop_det  = scl_s & scl_prev & ~sda_prev & sda_s;

endmodule

// File: rtl/tw_byte_shift.sv
module tw_byte_shift #(
    parameter int W = 8,
    localparam int CW = $clog2(W + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cnt_clr,
    input  logic         cnt_inc,
    input  logic         in_en,
    input  logic         in_bit,
    input  logic         load_en,
    input  logic [W-1:0] load_val,
    input  logic         left_en,
    output logic [W-1:0] data_q,
    output logic         full
);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (cnt_clr || load_en) begin
            cnt_q <= '0;
        end else if (cnt_inc) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (load_en) begin
            data_q <= load_val;
        end else if (in_en) begin
            data_q <= {data_q[W-2:0], in_bit};
        end else if (left_en) begin
            data_q <= {data_q[W-2:0], 1'b0};
        end
    end

    assign full = (cnt_q == CW'(W));

endmodule

// File: rtl/tw_addr_match.sv
module tw_addr_match #(
    parameter int              TYPE_W   = 4,
    parameter int              STRAP_W  = 3,
    parameter logic [TYPE_W-1:0] DEV_TYPE = 4'b0101,
    localparam int             BYTE_W   = TYPE_W + STRAP_W + 1
) (
    input  logic [BYTE_W-1:0]  addr_byte,
    input  logic [STRAP_W-1:0] strap,
    output logic               hit,
    output logic               is_read
);

    logic type_ok, strap_ok;

    assign type_ok  = (addr_byte[BYTE_W-1 -: TYPE_W] == DEV_TYPE);
    assign strap_ok = (addr_byte[STRAP_W:1] == strap);
    assign hit      = type_ok & strap_ok;
    assign is_read  = addr_byte[0];

endmodule

// File: rtl/tw_slave_fe.sv
module tw_slave_fe #(
    parameter int         SYNC_STAGES = 2,
    parameter int         TYPE_W      = 4,
    parameter int         STRAP_W     = 3,
    parameter logic [3:0] DEV_TYPE    = 4'b0101,
    localparam int        BYTE_W      = TYPE_W + STRAP_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_i,
    input  logic               sda_i,
    output logic               sda_pull_o,
    input  logic [STRAP_W-1:0] strap_i,
    input  logic               updn_cs_n_i,
    input  logic               nv_busy_i,
    output logic               rx_valid_o,
    output logic               rx_first_o,
    output logic [BYTE_W-1:0]  rx_byte_o,
    input  logic [BYTE_W-1:0]  rd_byte_i,
    output logic               rd_take_o,
    output logic               bus_stop_o
);
    import tw_slave_pkg::*;

    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

    tw_line_cond #(.SYNC_STAGES(SYNC_STAGES)) u_cond (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    logic              cnt_clr, cnt_inc, in_en, load_en, left_en, full;
    logic [BYTE_W-1:0] shift_q;

    tw_byte_shift #(.W(BYTE_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .cnt_clr  (cnt_clr),
        .cnt_inc  (cnt_inc),
        .in_en    (in_en),
        .in_bit   (sda_s),
        .load_en  (load_en),
        .load_val (rd_byte_i),
        .left_en  (left_en),
        .data_q   (shift_q),
        .full     (full)
    );

    logic addr_hit, addr_rd;

    tw_addr_match #(
        .TYPE_W   (TYPE_W),
        .STRAP_W  (STRAP_W),
        .DEV_TYPE (DEV_TYPE[TYPE_W-1:0])
    ) u_match (
        .addr_byte (shift_q),
        .strap     (strap_i),
        .hit       (addr_hit),
        .is_read   (addr_rd)
    );

    tw_state_t state_q, state_d;
    logic      pull_q, pull_d;
    logic      first_q, first_d;
    logic      sel_q, sel_d;
    logic      rw_q, rw_d;
    logic      mack_q, mack_d;
    logic      bus_live;

    // bus events inside a transfer; START/STOP and chip select take priority
    assign bus_live = updn_cs_n_i & ~start_det & ~stop_det;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            pull_q  <= 1'b0;
            first_q <= 1'b0;
            sel_q   <= 1'b0;
            rw_q    <= 1'b0;
            mack_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            pull_q  <= pull_d;
            first_q <= first_d;
            sel_q   <= sel_d;
            rw_q    <= rw_d;
            mack_q  <= mack_d;
        end
    end

    // next state and datapath controls
    always_comb begin
        state_d = state_q;
        pull_d  = pull_q;
        first_d = first_q;
        sel_d   = sel_q;
        rw_d    = rw_q;
        mack_d  = mack_q;
        cnt_clr = 1'b0;
        cnt_inc = 1'b0;
        in_en   = 1'b0;
        load_en = 1'b0;
        left_en = 1'b0;
        if (!updn_cs_n_i) begin
            state_d = ST_IDLE;
            pull_d  = 1'b0;
            sel_d   = 1'b0;
        end else if (start_det) begin
            state_d = ST_ADDR;
            pull_d  = 1'b0;
            sel_d   = 1'b0;
            cnt_clr = 1'b1;
        end else if (stop_det) begin
            state_d = ST_IDLE;
            pull_d  = 1'b0;
            sel_d   = 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    pull_d = 1'b0;
                end
                ST_ADDR: begin
                    if (scl_rise && !full) begin
                        in_en   = 1'b1;
                        cnt_inc = 1'b1;
                    end else if (scl_fall && full) begin
                        if (addr_hit && !nv_busy_i) begin
                            state_d = ST_ADDR_ACK;
                            pull_d  = 1'b1;
                            rw_d    = addr_rd;
                            sel_d   = 1'b1;
                        end else begin
                            state_d = ST_HOLD;
                            pull_d  = 1'b0;
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) begin
                        if (rw_q) begin
                            state_d = ST_RD_BYTE;
                            load_en = 1'b1;
                            pull_d  = ~rd_byte_i[BYTE_W-1];
                        end else begin
                            state_d = ST_WR_BYTE;
                            pull_d  = 1'b0;
                            cnt_clr = 1'b1;
                            first_d = 1'b1;
                        end
                    end
                end
                ST_WR_BYTE: begin
                    if (scl_rise && !full) begin
                        in_en   = 1'b1;
                        cnt_inc = 1'b1;
                    end else if (scl_fall && full) begin
                        state_d = ST_WR_ACK;
                        pull_d  = 1'b1;
                        first_d = 1'b0;
                    end
                end
                ST_WR_ACK: begin
                    if (scl_fall) begin
                        state_d = ST_WR_BYTE;
                        pull_d  = 1'b0;
                        cnt_clr = 1'b1;
                    end
                end
                ST_RD_BYTE: begin
                    if (scl_rise && !full) begin
                        cnt_inc = 1'b1;
                    end else if (scl_fall) begin
                        if (full) begin
                            state_d = ST_RD_ACK;
                            pull_d  = 1'b0;
                        end else begin
                            pull_d  = ~shift_q[BYTE_W-2];
                            left_en = 1'b1;
                        end
                    end
                end
                ST_RD_ACK: begin
                    if (scl_rise) begin
                        mack_d = ~sda_s;
                    end else if (scl_fall) begin
                        if (mack_q) begin
                            state_d = ST_RD_BYTE;
                            load_en = 1'b1;
                            pull_d  = ~rd_byte_i[BYTE_W-1];
                        end else begin
                            state_d = ST_HOLD;
                            pull_d  = 1'b0;
                        end
                    end
                end
                ST_HOLD: begin
                    pull_d = 1'b0;
                end
                default: begin
                    state_d = ST_IDLE;
                    pull_d  = 1'b0;
                end
            endcase
        end
    end

    // output pulses
    always_comb begin
        rx_valid_o = 1'b0;
        rd_take_o  = 1'b0;
        bus_stop_o = updn_cs_n_i & stop_det & sel_q;
        if (bus_live && scl_fall) begin
            unique case (state_q)
                ST_WR_BYTE:  rx_valid_o = full;
                ST_ADDR_ACK: rd_take_o  = rw_q;
                ST_RD_ACK:   rd_take_o  = mack_q;
                default: begin
                    rx_valid_o = 1'b0;
                    rd_take_o  = 1'b0;
                end
            endcase
        end
    end

    assign sda_pull_o = pull_q;
    assign rx_first_o = first_q;
    assign rx_byte_o  = shift_q;

endmodule

// File: rtl/tw_slave_fe_chk.sv
module tw_slave_fe_chk
    import tw_slave_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input logic      updn_cs_n,
    input logic      scl_s,
    input logic      sda_pull,
    input logic      nv_busy,
    input logic      rx_valid,
    input logic      rd_take,
    input logic      bus_stop,
    input tw_state_t state
);

    a_r9_release_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !updn_cs_n |=> !sda_pull);

    a_r3_busy_blocks_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ADDR_ACK && $past(state) == ST_ADDR) |-> !$past(nv_busy));

    a_r11_pull_moves_low: assert property (@(posedge clk) disable iff (!rst_n)
        (updn_cs_n && $past(updn_cs_n) && (sda_pull != $past(sda_pull))) |-> !$past(scl_s));

    a_r4_rx_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    a_r8_stop_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        bus_stop |=> state == ST_IDLE);

    a_r5_take_clock_low: assert property (@(posedge clk) disable iff (!rst_n)
        rd_take |-> !scl_s);

endmodule

bind tw_slave_fe tw_slave_fe_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .updn_cs_n (updn_cs_n_i),
    .scl_s     (scl_s),
    .sda_pull  (sda_pull_o),
    .nv_busy   (nv_busy_i),
    .rx_valid  (rx_valid_o),
    .rd_take   (rd_take_o),
    .bus_stop  (bus_stop_o),
    .state     (state_q)
);

// File: tb/tw_slave_fe_tb.sv
module tw_slave_fe_tb;

    localparam int CLK_PERIOD = 10;
    localparam int Q = 6;
    localparam logic [2:0] STRAP = 3'b101;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1, sda_m = 1'b1;
    logic updn_cs_n = 1'b1, nv_busy = 1'b0;
    logic sda_pull, rx_valid, rx_first, rd_take, bus_stop;
    logic [7:0] rx_byte, rd_byte;
    logic sda_line;
    int   take_cnt = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    assign sda_line = sda_m & ~sda_pull;
    assign rd_byte  = 8'hA0 + 8'(take_cnt);

    tw_slave_fe u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_i       (scl),
        .sda_i       (sda_line),
        .sda_pull_o  (sda_pull),
        .strap_i     (STRAP),
        .updn_cs_n_i (updn_cs_n),
        .nv_busy_i   (nv_busy),
        .rx_valid_o  (rx_valid),
        .rx_first_o  (rx_first),
        .rx_byte_o   (rx_byte),
        .rd_byte_i   (rd_byte),
        .rd_take_o   (rd_take),
        .bus_stop_o  (bus_stop)
    );

    // register bank model: advances after each take
    always @(posedge clk) if (rd_take) take_cnt <= take_cnt + 1;

    int   n_chk = 0, n_fail = 0, rx_n = 0, stop_n = 0, exp_idx = 0;
    logic [7:0] rx_log [32];
    logic       first_log [32];
    bit   done = 1'b0;

    always @(negedge clk) begin
        if (rx_valid && rx_n < 32) begin
            rx_log[rx_n]    = rx_byte;
            first_log[rx_n] = rx_first;
            rx_n++;
        end
        if (bus_stop) stop_n++;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_bit(input logic b, output logic r, output logic stable);
        logic r0;
        sda_m = b; wt(Q);
        scl = 1'b1; wt(1);
        r0 = sda_line; wt(Q);
        r = sda_line;
        stable = (r0 == r);
        wt(Q - 1);
        scl = 1'b0; wt(Q);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wt(Q);
        scl = 1'b1; wt(Q);
        sda_m = 1'b0; wt(Q);
        scl = 1'b0; wt(Q);
    endtask

    task automatic bus_stop_t();
        sda_m = 1'b0; wt(Q);
        scl = 1'b1; wt(Q);
        sda_m = 1'b1; wt(2 * Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic r, s;
        for (int i = 7; i >= 0; i--) bus_bit(b[i], r, s);
        bus_bit(1'b1, r, s);
        ack = ~r;
    endtask

    task automatic read_byte(input logic mack, output logic [7:0] v, output logic stable);
        logic r, s;
        stable = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            bus_bit(1'b1, r, s);
            v[i] = r;
            stable &= s;
        end
        bus_bit(~mack, r, s);
    endtask

    // {address byte, nv_busy, expected acknowledge}
    localparam logic [9:0] VEC [8] = '{
        {8'h5A, 1'b0, 1'b1},
        {8'h5B, 1'b0, 1'b1},
        {8'h5A, 1'b1, 1'b0},
        {8'h5B, 1'b1, 1'b0},
        {8'h5C, 1'b0, 1'b0},
        {8'h7A, 1'b0, 1'b0},
        {8'h4B, 1'b0, 1'b0},
        {8'h58, 1'b0, 1'b0}
    };

    initial begin
        logic       ack, st;
        logic [7:0] v;
        int         rx0, st0;

        wt(5);
        // R10: reset state
        check(sda_pull == 1'b0, "R10 pull after reset", sda_pull, 0);
        check(!rx_valid && !rd_take && !bus_stop, "R10 pulses after reset",
              {rx_valid, rd_take, bus_stop}, 0);
        rst_n = 1'b1;
        wt(5);

        // R1 R3 R2: address table
        foreach (VEC[k]) begin
            rx0 = rx_n; st0 = stop_n;
            nv_busy = VEC[k][1];
            bus_start();
            send_byte(VEC[k][9:2], ack);
            check(ack == VEC[k][0], "R1 R2 R3 address acknowledge", ack, VEC[k][0]);
            if (ack && VEC[k][2]) begin
                read_byte(1'b0, v, st);
                check(v == 8'hA0 + 8'(exp_idx), "R5 read byte", v, 8'hA0 + 8'(exp_idx));
                exp_idx++;
            end
            bus_stop_t();
            nv_busy = 1'b0;
            check(rx_n == rx0, "R2 no byte presented", rx_n, rx0);
            check(stop_n - st0 == int'(VEC[k][0]), "R8 stop pulse", stop_n - st0, VEC[k][0]);
        end

        // R4 R8: write register address then data
        rx0 = rx_n; st0 = stop_n;
        bus_start();
        send_byte(8'h5A, ack);
        send_byte(8'h03, ack);
        check(ack, "R4 ack register address", ack, 1);
        send_byte(8'h3A, ack);
        check(ack, "R4 ack data byte", ack, 1);
        bus_stop_t();
        check(rx_n == rx0 + 2, "R4 byte count", rx_n - rx0, 2);
        check(rx_log[rx0] == 8'h03 && first_log[rx0], "R4 first byte",
              {first_log[rx0], rx_log[rx0]}, 9'h103);
        check(rx_log[rx0+1] == 8'h3A && !first_log[rx0+1], "R4 second byte",
              {first_log[rx0+1], rx_log[rx0+1]}, 9'h03A);
        check(stop_n == st0 + 1, "R8 stop after write", stop_n - st0, 1);

        // R5 R6 R11: three-byte read, ack ack nack
        bus_start();
        send_byte(8'h5B, ack);
        for (int j = 0; j < 3; j++) begin
            read_byte(j < 2, v, st);
            check(v == 8'hA0 + 8'(exp_idx), "R5 R6 sequential read", v, 8'hA0 + 8'(exp_idx));
            check(st, "R11 data stable while clock high", st, 1);
            exp_idx++;
        end
        send_byte(8'h00, ack);
        check(!ack, "R6 released after no-acknowledge", ack, 0);
        check(take_cnt == exp_idx, "R6 no fetch after no-acknowledge", take_cnt, exp_idx);
        bus_stop_t();

        // R7: repeated START re-arms the first flag
        rx0 = rx_n;
        bus_start();
        send_byte(8'h5A, ack);
        send_byte(8'h22, ack);
        bus_start();
        send_byte(8'h5A, ack);
        check(ack, "R7 ack after repeated start", ack, 1);
        send_byte(8'h33, ack);
        bus_stop_t();
        check(rx_n == rx0 + 2 && rx_log[rx0+1] == 8'h33 && first_log[rx0+1], "R7 first flag re-armed",
              {first_log[rx0+1], rx_log[rx0+1]}, 9'h133);

        // R2: bytes after a mismatch are ignored
        rx0 = rx_n; st0 = stop_n;
        bus_start();
        send_byte(8'h5C, ack);
        send_byte(8'h55, ack);
        check(!ack, "R2 no ack after mismatch", ack, 0);
        bus_stop_t();
        check(rx_n == rx0 && stop_n == st0, "R2 nothing presented", rx_n - rx0, 0);

        // R9: chip select low hides the bus
        rx0 = rx_n;
        updn_cs_n = 1'b0;
        bus_start();
        send_byte(8'h5A, ack);
        check(!ack, "R9 ignored while select low", ack, 0);
        send_byte(8'h44, ack);
        bus_stop_t();
        updn_cs_n = 1'b1;
        check(rx_n == rx0, "R9 no byte while select low", rx_n - rx0, 0);

        // R3: busy polling then release
        nv_busy = 1'b1;
        bus_start();
        send_byte(8'h5B, ack);
        bus_stop_t();
        check(!ack, "R3 read poll while busy", ack, 0);
        nv_busy = 1'b0;
        bus_start();
        send_byte(8'h5B, ack);
        check(ack, "R3 read poll after busy", ack, 1);
        read_byte(1'b0, v, st);
        check(v == 8'hA0 + 8'(exp_idx), "R5 read after poll", v, 8'hA0 + 8'(exp_idx));
        exp_idx++;
        bus_stop_t();

        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule